// File: doc/BRIEF.md
# Graphics integer add/subtract unit

This unit performs modular integer addition and subtraction on the raw bit patterns held in floating-point registers. A width bit selects between two forms. The narrow form treats each operand as one 32-bit register word. The wide form builds each 64-bit operand from an even/odd register pair and writes a 64-bit result back to a destination pair. The issuing logic presents the sub-opcode, the width bit, the pipeline bit and the four source words in one cycle. The unit returns the register-file write enables and write data in that same cycle.

The unit has a single pipe stage. A pipelined operation writes back whatever the stage currently holds, which is the result of the previous pipelined operation, and then captures its own result at the clock edge. The stage keeps the width of the operation that filled it. A retiring value is therefore written as one register or as a pair, according to how that value was produced. A non-pipelined operation bypasses the stage entirely.

Top module: `gfx_iaddsub`

## Requirements
- R1: With `op_valid` high and `sub_op` equal to 0x49, the unit adds. In the narrow form (`dbl` = 0), a non-pipelined add writes `src1_even + src2_even` modulo 2^32 on `wr_even_data` with `wr_even_en` = 1 and `wr_odd_en` = 0, in the same cycle.
- R2: `sub_op` equal to 0x4D subtracts, giving src1 minus src2 modulo the operand width.
- R3: With `dbl` = 1, each operand is `{srcN_odd, srcN_even}` (the odd word is the upper half) and the result is taken modulo 2^64, so carries and borrows cross between the halves.
- R4: A 64-bit result is written with its low half on `wr_even_data` and its high half on `wr_odd_data`, and both `wr_even_en` and `wr_odd_en` are 1.
- R5: A non-pipelined operation (`piped` = 0) leaves the pipe stage unchanged. A later pipelined operation still retires the value that was held before it.
- R6: A pipelined operation (`piped` = 1) writes the value held in the stage in the current cycle, and the stage takes the new result at the next rising clock edge.
- R7: A retiring value is written at the width of the operation that produced it. A narrow producer drives only `wr_even_en`, and a wide producer drives both enables, whatever the width bit of the retiring operation.
- R8: Reset (`rst_n` low, asynchronous) clears the stage to value zero with a narrow width tag. The first pipelined operation after reset therefore writes 0 to a single register.
- R9: When `op_valid` is low, or when `sub_op` is neither 0x49 nor 0x4D, both write enables are 0 and the stage is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is issued this cycle |
| sub_op | input | 7 | Sub-opcode: 0x49 add, 0x4D subtract |
| dbl | input | 1 | 1 = 64-bit pair form, 0 = 32-bit form |
| piped | input | 1 | 1 = pipelined through the single stage |
| src1_even | input | 32 | First operand, even register (low half) |
| src1_odd | input | 32 | First operand, odd register (high half) |
| src2_even | input | 32 | Second operand, even register (low half) |
| src2_odd | input | 32 | Second operand, odd register (high half) |
| wr_even_en | output | 1 | Write enable for the even (or only) destination register |
| wr_odd_en | output | 1 | Write enable for the odd destination register |
| wr_even_data | output | 32 | Data for the even destination register |
| wr_odd_data | output | 32 | Data for the odd destination register |

## Verification
A wrong stage value or width tag stays hidden until the next pipelined operation retires it. At that point it shows in the same cycle as wrong data or a wrong odd enable. The bench therefore places non-pipelined, illegal and idle operations between pipelined ones, and checks that the next retirement still returns the earlier result. Carry and borrow paths between the two halves appear only in the wide form, so the wide vectors are chosen so that the carry or borrow crosses word 0 into word 1.

// File: rtl/gfx_ia_pkg.sv
package gfx_ia_pkg;
  typedef enum logic [1:0] {
    IA_NONE = 2'd0,
    IA_ADD  = 2'd1,
    IA_SUB  = 2'd2
  } ia_kind_e;

  function automatic logic ia_legal(input ia_kind_e k);
    return k != IA_NONE;
  endfunction
endpackage

// File: rtl/gfx_ia_decode.sv
module gfx_ia_decode
  import gfx_ia_pkg::*;
#(
  parameter int OPC_W = 7,
  parameter logic [OPC_W-1:0] OPC_ADD = 7'h49,
  parameter logic [OPC_W-1:0] OPC_SUB = 7'h4D
) (
  input  logic             op_valid,
  input  logic [OPC_W-1:0] sub_op,
  output ia_kind_e         kind
);
  always_comb begin
    kind = IA_NONE;
    if (op_valid) begin
      if (sub_op == OPC_ADD)      kind = IA_ADD;
      else if (sub_op == OPC_SUB) kind = IA_SUB;
    end
  end
endmodule

// File: rtl/gfx_ia_alu.sv
module gfx_ia_alu
  import gfx_ia_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANES  = 2
) (
  input  ia_kind_e                 kind,
  input  logic                     dbl,
  input  logic [LANES*WORD_W-1:0]  opa,
  input  logic [LANES*WORD_W-1:0]  opb,
  output logic [LANES*WORD_W-1:0]  res
);
  localparam int FULL_W = LANES * WORD_W;

  // Subtraction as a + ~b + 1: invert the second operand, inject carry in lane 0.
  function automatic logic [WORD_W-1:0] lane_opnd(input logic [WORD_W-1:0] b,
                                                  input logic inv);
    return inv ? ~b : b;
  endfunction

  logic                   is_sub;
  logic [LANES:0]         carry;
  logic [FULL_W-1:0]      raw;

  assign is_sub   = (kind == IA_SUB);
  assign carry[0] = is_sub;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WORD_W-1:0] a_w, b_w;
    assign a_w = opa[i*WORD_W +: WORD_W];
    assign b_w = lane_opnd(opb[i*WORD_W +: WORD_W], is_sub);
    if (i < LANES - 1) begin : g_mid
      logic [WORD_W:0] s;
      assign s = {1'b0, a_w} + {1'b0, b_w} + {{WORD_W{1'b0}}, carry[i]};
      assign raw[i*WORD_W +: WORD_W] = s[WORD_W-1:0];
      assign carry[i+1] = s[WORD_W];
    end else begin : g_top
      assign raw[i*WORD_W +: WORD_W] = a_w + b_w + {{(WORD_W-1){1'b0}}, carry[i]};
      assign carry[i+1] = 1'b0;
    end
  end

  // Narrow form: only lane 0 is meaningful; upper lanes forced to zero.
  always_comb begin
    res = raw;
    if (!dbl) res[FULL_W-1:WORD_W] = '0;
  end

  logic unused_carry;
  assign unused_carry = carry[LANES];
endmodule

// File: rtl/gfx_ia_stage.sv
module gfx_ia_stage #(
  parameter int FULL_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FULL_W-1:0] d_val,
  input  logic              d_wide,
  output logic [FULL_W-1:0] q_val,
  output logic              q_wide
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_val  <= '0;
      q_wide <= 1'b0;
    end else if (load) begin
      q_val  <= d_val;
      q_wide <= d_wide;
    end
  end
endmodule

// File: rtl/gfx_ia_wrback.sv
module gfx_ia_wrback #(
  parameter int WORD_W = 32
) (
  input  logic              legal,
  input  logic              piped,
  input  logic              dbl,
  input  logic [2*WORD_W-1:0] now_val,
  input  logic [2*WORD_W-1:0] held_val,
  input  logic              held_wide,
  output logic              even_en,
  output logic              odd_en,
  output logic [WORD_W-1:0] even_data,
  output logic [WORD_W-1:0] odd_data
);
  logic [2*WORD_W-1:0] sel_val;
  logic                sel_wide;

  assign sel_val  = piped ? held_val  : now_val;
  assign sel_wide = piped ? held_wide : dbl;

  assign even_en   = legal;
  assign odd_en    = legal && sel_wide;
  assign even_data = sel_val[WORD_W-1:0];
  assign odd_data  = sel_val[2*WORD_W-1:WORD_W];
endmodule

// File: rtl/gfx_iaddsub.sv
module gfx_iaddsub
  import gfx_ia_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int OPC_W  = 7,
  parameter logic [OPC_W-1:0] OPC_ADD = 7'h49,
  parameter logic [OPC_W-1:0] OPC_SUB = 7'h4D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OPC_W-1:0]  sub_op,
  input  logic              dbl,
  input  logic              piped,
  input  logic [WORD_W-1:0] src1_even,
  input  logic [WORD_W-1:0] src1_odd,
  input  logic [WORD_W-1:0] src2_even,
  input  logic [WORD_W-1:0] src2_odd,
  output logic              wr_even_en,
  output logic              wr_odd_en,
  output logic [WORD_W-1:0] wr_even_data,
  output logic [WORD_W-1:0] wr_odd_data
);
  localparam int FULL_W = 2 * WORD_W;

  ia_kind_e          op_kind;
  logic              op_legal;
  logic              stage_load;
  logic [FULL_W-1:0] alu_res;
  logic [FULL_W-1:0] stage_val;
  logic              stage_wide;

  gfx_ia_decode #(.OPC_W(OPC_W), .OPC_ADD(OPC_ADD), .OPC_SUB(OPC_SUB)) u_dec (
    .op_valid (op_valid),
    .sub_op   (sub_op),
    .kind     (op_kind)
  );

  assign op_legal   = ia_legal(op_kind);
  assign stage_load = op_legal && piped;

  gfx_ia_alu #(.WORD_W(WORD_W), .LANES(2)) u_alu (
    .kind (op_kind),
    .dbl  (dbl),
    .opa  ({src1_odd, src1_even}),
    .opb  ({src2_odd, src2_even}),
    .res  (alu_res)
  );

  gfx_ia_stage #(.FULL_W(FULL_W)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (stage_load),
    .d_val  (alu_res),
    .d_wide (dbl),
    .q_val  (stage_val),
    .q_wide (stage_wide)
  );

  gfx_ia_wrback #(.WORD_W(WORD_W)) u_wb (
    .legal     (op_legal),
    .piped     (piped),
    .dbl       (dbl),
    .now_val   (alu_res),
    .held_val  (stage_val),
    .held_wide (stage_wide),
    .even_en   (wr_even_en),
    .odd_en    (wr_odd_en),
    .even_data (wr_even_data),
    .odd_data  (wr_odd_data)
  );
endmodule

// File: rtl/gfx_iaddsub_chk.sv
module gfx_iaddsub_chk #(
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                piped,
  input logic                dbl,
  input logic                op_legal,
  input logic [WORD_W-1:0]   src1_even,
  input logic [WORD_W-1:0]   src1_odd,
  input logic [WORD_W-1:0]   src2_even,
  input logic [WORD_W-1:0]   src2_odd,
  input logic                add_sel,
  input logic                wr_even_en,
  input logic                wr_odd_en,
  input logic [WORD_W-1:0]   wr_even_data,
  input logic [WORD_W-1:0]   wr_odd_data,
  input logic [2*WORD_W-1:0] alu_res,
  input logic [2*WORD_W-1:0] stage_val,
  input logic                stage_wide
);
  a_r1_narrow_single: assert property (@(posedge clk) disable iff (!rst_n)
    (op_legal && !piped && !dbl) |-> (wr_even_en && !wr_odd_en));

  a_r3_wide_add: assert property (@(posedge clk) disable iff (!rst_n)
    (op_legal && !piped && dbl && add_sel) |->
      ({wr_odd_data, wr_even_data} == {src1_odd, src1_even} + {src2_odd, src2_even}));

  a_r4_pair_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_legal && !piped && dbl) |-> (wr_even_en && wr_odd_en));

  a_r5_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_legal && piped) |=> ($stable(stage_val) && $stable(stage_wide)));

  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (op_legal && piped) |=> (stage_val == $past(alu_res) && stage_wide == $past(dbl)));

  a_r6_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (op_legal && piped) |-> (wr_even_en && wr_even_data == stage_val[WORD_W-1:0]));

  a_r7_width_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_legal && piped) |-> (wr_odd_en == stage_wide));

  a_r8_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (stage_val == '0 && !stage_wide));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_legal |-> (!wr_even_en && !wr_odd_en));
endmodule

bind gfx_iaddsub gfx_iaddsub_chk #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .piped        (piped),
  .dbl          (dbl),
  .op_legal     (op_legal),
  .src1_even    (src1_even),
  .src1_odd     (src1_odd),
  .src2_even    (src2_even),
  .src2_odd     (src2_odd),
  .add_sel      (op_kind == gfx_ia_pkg::IA_ADD),
  .wr_even_en   (wr_even_en),
  .wr_odd_en    (wr_odd_en),
  .wr_even_data (wr_even_data),
  .wr_odd_data  (wr_odd_data),
  .alu_res      (alu_res),
  .stage_val    (stage_val),
  .stage_wide   (stage_wide)
);

// File: tb/sim_gfx_iaddsub.sv
module sim_gfx_iaddsub;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NVEC = 8;

  // {op[7], dbl, a_odd, a_even, b_odd, b_even, exp_odd, exp_even}
  localparam logic [199:0] VEC [NVEC] = '{
    {7'h49, 1'b0, 32'h0, 32'h5, 32'h0, 32'h3, 32'h0, 32'h8},
    {7'h49, 1'b0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h2, 32'h0, 32'h1},
    {7'h4D, 1'b0, 32'h0, 32'h3, 32'h0, 32'h5, 32'h0, 32'hFFFF_FFFE},
    {7'h49, 1'b0, 32'hDEAD_BEEF, 32'h10, 32'h1234, 32'h20, 32'h0, 32'h30},
    {7'h49, 1'b1, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h1, 32'h1, 32'h0},
    {7'h4D, 1'b1, 32'h1, 32'h0, 32'h0, 32'h1, 32'h0, 32'hFFFF_FFFF},
    {7'h49, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h1, 32'h0, 32'h0},
    {7'h4D, 1'b1, 32'h0, 32'h0, 32'h0, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [6:0] sub_op = '0;
  logic dbl = 1'b0;
  logic piped = 1'b0;
  logic [W-1:0] src1_even = '0, src1_odd = '0, src2_even = '0, src2_odd = '0;
  logic wr_even_en, wr_odd_en;
  logic [W-1:0] wr_even_data, wr_odd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gfx_iaddsub u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .sub_op(sub_op),
    .dbl(dbl), .piped(piped),
    .src1_even(src1_even), .src1_odd(src1_odd),
    .src2_even(src2_even), .src2_odd(src2_odd),
    .wr_even_en(wr_even_en), .wr_odd_en(wr_odd_en),
    .wr_even_data(wr_even_data), .wr_odd_data(wr_odd_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one op on the falling edge; outputs settle 1 ns later.
  task automatic issue(input bit v, input logic [6:0] op, input bit d, input bit p,
                       input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    op_valid = v; sub_op = op; dbl = d; piped = p;
    {src1_odd, src1_even} = a;
    {src2_odd, src2_even} = b;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    op_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    #1;
    chk("R8", "even_en after reset", {63'b0, wr_even_en}, 64'd0);
    chk("R8", "odd_en after reset", {63'b0, wr_odd_en}, 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [199:0] v;
      string rq;
      v = VEC[i];
      issue(1'b1, v[199:193], v[192], 1'b0, v[191:128], v[127:64]);
      rq = v[192] ? "R3" : (v[199:193] == 7'h49 ? "R1" : "R2");
      chk(rq, "even data", {32'b0, wr_even_data}, {32'b0, v[31:0]});
      chk(v[192] ? "R4" : "R1", "odd_en", {63'b0, wr_odd_en}, {63'b0, v[192]});
      chk("R4", "even_en", {63'b0, wr_even_en}, 64'd1);
      if (v[192]) chk("R4", "odd data", {32'b0, wr_odd_data}, {32'b0, v[63:32]});
    end

    // Stage untouched by the non-pipelined table: first retire is zero, narrow.
    issue(1'b1, 7'h49, 1'b0, 1'b1, 64'd1, 64'd1);
    chk("R5", "retire after nonpiped ops", {32'b0, wr_even_data}, 64'd0);
    chk("R8", "retire width after reset", {63'b0, wr_odd_en}, 64'd0);

    // Wide pipelined op retires the narrow value 2.
    issue(1'b1, 7'h49, 1'b1, 1'b1, 64'h1_0000_0005, 64'h2_0000_0003);
    chk("R6", "retire previous result", {32'b0, wr_even_data}, 64'd2);
    chk("R7", "narrow producer odd_en", {63'b0, wr_odd_en}, 64'd0);

    issue(1'b1, 7'h48, 1'b1, 1'b1, 64'd7, 64'd7);
    chk("R9", "illegal opcode even_en", {63'b0, wr_even_en}, 64'd0);
    chk("R9", "illegal opcode odd_en", {63'b0, wr_odd_en}, 64'd0);
    issue(1'b0, 7'h49, 1'b1, 1'b1, 64'd7, 64'd7);
    chk("R9", "idle even_en", {63'b0, wr_even_en}, 64'd0);

    issue(1'b1, 7'h4D, 1'b0, 1'b0, 64'd10, 64'd4);
    chk("R5", "nonpiped immediate sub", {32'b0, wr_even_data}, 64'd6);

    // Retire the wide 0x3_00000008 from a narrow pipelined sub.
    issue(1'b1, 7'h4D, 1'b0, 1'b1, 64'd9, 64'd2);
    chk("R7", "wide producer odd_en", {63'b0, wr_odd_en}, 64'd1);
    chk("R6", "retired pair", {wr_odd_data, wr_even_data}, 64'h3_0000_0008);
    issue(1'b1, 7'h49, 1'b1, 1'b1, 64'd0, 64'd0);
    chk("R6", "retired narrow sub", {32'b0, wr_even_data}, 64'd7);

    // Reset mid-run clears a wide stage value.
    do_reset();
    issue(1'b1, 7'h4D, 1'b1, 1'b1, 64'd0, 64'd0);
    chk("R8", "retire after second reset", {wr_odd_data, wr_even_data}, 64'd0);
    chk("R8", "width after second reset", {63'b0, wr_odd_en}, 64'd0);
    issue(1'b1, 7'h49, 1'b0, 1'b1, 64'd1, 64'd1);
    chk("R7", "wide zero retire odd_en", {63'b0, wr_odd_en}, 64'd1);

    issue(1'b0, 7'h0, 1'b0, 1'b0, 64'd0, 64'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule